// File: doc/BRIEF.md
# Diagnostic Output Selector with Bypass Dividers

This block produces a main clock output and a single-ended diagnostic output for a clock synthesizer. A 3-bit test-select code picks what appears on the diagnostic pin: the serial configuration bit stream, a constant, the crystal reference halved, the feedback counter, the main clock, or the main clock divided by four. One code, bypass, takes the synthesized clock out of the path. The low-speed serial clock then drives both the feedback counter and the post divider, so board-level debug can step the output clock by hand.

The block runs on one fast core clock. Each source clock (serial, synthesized, crystal) arrives as a one-core-cycle event strobe that marks a rising edge of that source. The analog loop is not part of this block. The feedback counter makes a one-period high pulse on every Mth source event, and M = 0 counts as 1. The post divider toggles the main output once every N source events, where N is 1, 2, 4 or 8, so the output keeps a 50% duty cycle. The diagnostic output is registered.

Top module: `tsel_diag`

## Requirements
- R1: After reset, `fout` and `test_out` are 0, and both dividers, the crystal halver and the quarter divider start from a cleared count.
- R2: With `t_sel` = 3'b000, `test_out` is the value `shift_bit` had at the previous core clock edge.
- R3: With `t_sel` = 3'b001, `test_out` is 1. With `t_sel` = 3'b101, `test_out` is 0.
- R4: With `t_sel` = 3'b010, `test_out` is the crystal halver. It starts at 0 and toggles on every `xtal_tick`.
- R5: The feedback counter's output is high after the k-th divider event exactly when k > 0 and k mod M = 0, where M = `m_val`, or 1 when `m_val` is 0. Outside bypass its events are `synth_tick`. With `t_sel` = 3'b011 it drives `test_out`.
- R6: The `n_sel` codes 00, 01, 10 and 11 give N = 1, 2, 4 and 8. `fout` starts at 0 and inverts on every Nth divider event, so after k events it equals (k / N) mod 2. Outside bypass the divider events are `synth_tick`.
- R7: With `t_sel` = 3'b100, `test_out` follows `fout`. With `t_sel` = 3'b111, it follows `fout` divided by four. That signal inverts on every odd-numbered rising edge of `fout`, so after r rising edges it equals ((r + 1) / 2) mod 2.
- R8: With `t_sel` = 3'b110 (bypass), both dividers count `sclk_tick` and ignore `synth_tick`, and `test_out` carries the feedback counter.
- R9: `test_out` changes at the first core clock edge after a change of `t_sel` or of the selected source, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_tick | input | 1 | One-cycle strobe per serial clock rising edge |
| synth_tick | input | 1 | One-cycle strobe per synthesized clock rising edge |
| xtal_tick | input | 1 | One-cycle strobe per crystal reference rising edge |
| shift_bit | input | 1 | Serial output of the configuration shift register |
| m_val | input | 7 | Feedback divide value M (0 treated as 1) |
| n_sel | input | 2 | Post divider code, N = 2^n_sel |
| t_sel | input | 3 | Diagnostic select code |
| fout | output | 1 | Main clock output |
| test_out | output | 1 | Diagnostic output |

## Verification
Each phase resets the block, fixes one M (0, 1, small odd and even values, random) and one N code, and then applies random mixes of the three source strobes while the select code changes at random. This separates the routing of events between the synthesized and serial sources, because a synthesized event during bypass must leave every count alone. M = 0 and M = 1 separate the zero-as-one rule from a plain counter. The four N codes separate the toggle spacing from the exponent decoding. A directed step shows that the registered diagnostic output lags a select change by exactly one edge.

// File: rtl/tsel_diag_pkg.sv
package tsel_diag_pkg;

  typedef enum logic [2:0] {
    SEL_SHIFT  = 3'b000,
    SEL_ONE    = 3'b001,
    SEL_XHALF  = 3'b010,
    SEL_MCNT   = 3'b011,
    SEL_FOUT   = 3'b100,
    SEL_ZERO   = 3'b101,
    SEL_BYPASS = 3'b110,
    SEL_FQUART = 3'b111
  } tsel_e;

endpackage

// File: rtl/tsel_diag_rstsync.sv
module tsel_diag_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tsel_diag_mcount.sv
module tsel_diag_mcount #(
  parameter int M_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev,
  input  logic [M_W-1:0] m_val,
  output logic           pulse
);

  logic [M_W-1:0] cnt_q, cnt_d;
  logic           pulse_q, pulse_d;
  logic [M_W-1:0] m_eff;
  logic           wrap;

  // a zero divide value behaves as one
  assign m_eff = (m_val == '0) ? M_W'(1) : m_val;
  assign wrap  = (cnt_q >= m_eff - M_W'(1));

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = pulse_q;
    if (ev) begin
      if (wrap) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d   = cnt_q + M_W'(1);
        pulse_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (ev) begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/tsel_diag_postdiv.sv
module tsel_diag_postdiv #(
  parameter int N_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev,
  input  logic [N_W-1:0] n_sel,
  output logic           q,
  output logic           rise
);

  localparam int CW = (1 << N_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_m1;
  logic          q_q, q_d;
  logic          wrap;

  // N - 1 for N = 2^n_sel: a run of n_sel ones
  assign lim_m1 = {CW{1'b1}} >> (CW - int'(n_sel));
  assign wrap   = (cnt_q >= lim_m1);

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (ev) begin
      if (wrap) begin
        cnt_d = '0;
        q_d   = ~q_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (ev) begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign q    = q_q;
  assign rise = ev & wrap & ~q_q;

endmodule

// File: rtl/tsel_diag_divchain.sv
module tsel_diag_divchain #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_in,
  output logic q
);

  logic [STAGES-1:0] q_s;
  logic [STAGES-1:0] ev_s;

  assign ev_s[0] = ev_in;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i > 0) begin : g_link
      // the next stage advances when this one goes low to high
      assign ev_s[i] = ev_s[i-1] & ~q_s[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_s[i] <= 1'b0;
      end else if (ev_s[i]) begin
        q_s[i] <= ~q_s[i];
      end
    end
  end

  assign q = q_s[STAGES-1];

endmodule

// File: rtl/tsel_diag_mux.sv
module tsel_diag_mux
  import tsel_diag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] t_sel,
  input  logic       shift_bit,
  input  logic       xtal_half,
  input  logic       m_pulse,
  input  logic       fout,
  input  logic       fout_quart,
  output logic       test_out
);

  logic out_d, out_q;

  always_comb begin
    case (tsel_e'(t_sel))
      SEL_SHIFT:  out_d = shift_bit;
      SEL_ONE:    out_d = 1'b1;
      SEL_XHALF:  out_d = xtal_half;
      SEL_MCNT:   out_d = m_pulse;
      SEL_FOUT:   out_d = fout;
      SEL_ZERO:   out_d = 1'b0;
      SEL_BYPASS: out_d = m_pulse;
      SEL_FQUART: out_d = fout_quart;
      default:    out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign test_out = out_q;

endmodule

// File: rtl/tsel_diag.sv
module tsel_diag
  import tsel_diag_pkg::*;
#(
  parameter int M_W         = 7,
  parameter int N_W         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_tick,
  input  logic           synth_tick,
  input  logic           xtal_tick,
  input  logic           shift_bit,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_sel,
  input  logic [2:0]     t_sel,
  output logic           fout,
  output logic           test_out
);

  localparam int QUART_STAGES = 2;

  logic rst_sync_n;
  logic bypass;
  logic div_ev;
  logic m_pulse;
  logic fout_rise;
  logic xtal_half;
  logic fout_quart;

  tsel_diag_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // bypass swaps the divider event source to the serial clock
  assign bypass = (t_sel == SEL_BYPASS);
  assign div_ev = bypass ? sclk_tick : synth_tick;

  tsel_diag_mcount #(.M_W(M_W)) u_mcnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ev    (div_ev),
    .m_val (m_val),
    .pulse (m_pulse)
  );

  tsel_diag_postdiv #(.N_W(N_W)) u_post (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ev    (div_ev),
    .n_sel (n_sel),
    .q     (fout),
    .rise  (fout_rise)
  );

  tsel_diag_divchain #(.STAGES(1)) u_xhalf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ev_in (xtal_tick),
    .q     (xtal_half)
  );

  tsel_diag_divchain #(.STAGES(QUART_STAGES)) u_fquart (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ev_in (fout_rise),
    .q     (fout_quart)
  );

  tsel_diag_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .t_sel      (t_sel),
    .shift_bit  (shift_bit),
    .xtal_half  (xtal_half),
    .m_pulse    (m_pulse),
    .fout       (fout),
    .fout_quart (fout_quart),
    .test_out   (test_out)
  );

endmodule

// File: rtl/tsel_diag_chk.sv
module tsel_diag_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       sclk_tick,
  input logic       synth_tick,
  input logic       shift_bit,
  input logic [2:0] t_sel,
  input logic       fout,
  input logic       test_out
);

  AST_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (t_sel == 3'b000) |=> (test_out == $past(shift_bit))); // R2

  AST_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (t_sel == 3'b001) |=> test_out); // R3

  AST_CONST_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (t_sel == 3'b101) |=> !test_out); // R3

  AST_FOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sclk_tick && !synth_tick) |=> $stable(fout)); // R6

  AST_BYPASS_IGNORES_SYNTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (t_sel == 3'b110 && !sclk_tick) |=> $stable(fout)); // R8

  AST_NORMAL_IGNORES_SCLK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (t_sel != 3'b110 && !synth_tick) |=> $stable(fout)); // R6

endmodule

bind tsel_diag tsel_diag_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sclk_tick  (sclk_tick),
  .synth_tick (synth_tick),
  .shift_bit  (shift_bit),
  .t_sel      (t_sel),
  .fout       (fout),
  .test_out   (test_out)
);

// File: tb/tsel_diag_tb.sv
module tsel_diag_tb;

  logic       clk;
  logic       rst_n;
  logic       sclk_tick, synth_tick, xtal_tick, shift_bit;
  logic [6:0] m_val;
  logic [1:0] n_sel;
  logic [2:0] t_sel;
  logic       fout, test_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // model state
  int dk, xk, m_eff, n_eff;

  tsel_diag u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_tick  (sclk_tick),
    .synth_tick (synth_tick),
    .xtal_tick  (xtal_tick),
    .shift_bit  (shift_bit),
    .m_val      (m_val),
    .n_sel      (n_sel),
    .t_sel      (t_sel),
    .fout       (fout),
    .test_out   (test_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b (t_sel=%0d dk=%0d M=%0d N=%0d)",
               req, act, exp, t_sel, dk, m_eff, n_eff);
    end
  endtask

  function automatic bit exp_fout(int k, int n);
    return bit'((k / n) % 2);
  endfunction

  function automatic bit exp_quart(int k, int n);
    int r;
    r = ((k / n) + 1) / 2;
    return bit'(((r + 1) / 2) % 2);
  endfunction

  function automatic bit exp_m(int k, int m);
    return (k > 0) && (k % m == 0);
  endfunction

  function automatic bit exp_test(int ts, bit sh);
    case (ts)
      0:       return sh;
      1:       return 1'b1;
      2:       return bit'(xk % 2);
      3, 6:    return exp_m(dk, m_eff);
      4:       return exp_fout(dk, n_eff);
      5:       return 1'b0;
      default: return exp_quart(dk, n_eff);
    endcase
  endfunction

  function automatic string req_of(int ts);
    case (ts)
      0:       return "R2";
      1, 5:    return "R3";
      2:       return "R4";
      3:       return "R5";
      6:       return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic do_reset(input int m, input int ncode);
    @(negedge clk);
    rst_n = 1'b0;
    sclk_tick = 0; synth_tick = 0; xtal_tick = 0; shift_bit = 0;
    t_sel = 3'b000;
    m_val = 7'(m);
    n_sel = 2'(ncode);
    m_eff = (m == 0) ? 1 : m;
    n_eff = 1 << ncode;
    dk = 0; xk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(fout, 1'b0, "R1 fout");
    check(test_out, 1'b0, "R1 test_out");
  endtask

  // one stimulus step: strobes for one edge, one idle edge, then sample (R9 timing)
  task automatic step(input int ts, input bit sc, input bit sy, input bit xt, input bit sh);
    t_sel = 3'(ts); sclk_tick = sc; synth_tick = sy; xtal_tick = xt; shift_bit = sh;
    if (ts == 6) begin
      if (sc) dk++;
    end else begin
      if (sy) dk++;
    end
    if (xt) xk++;
    @(negedge clk);
    sclk_tick = 0; synth_tick = 0; xtal_tick = 0;
    @(negedge clk);
    check(fout, exp_fout(dk, n_eff), (ts == 6) ? "R8 fout" : "R6 fout");
    check(test_out, exp_test(ts, sh), req_of(ts));
  endtask

  initial begin
    int mlist[6];
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    sclk_tick = 0; synth_tick = 0; xtal_tick = 0; shift_bit = 0;
    m_val = '0; n_sel = '0; t_sel = '0;
    mlist[0] = 0; mlist[1] = 1; mlist[2] = 3; mlist[3] = 4;
    mlist[4] = $urandom_range(2, 9); mlist[5] = $urandom_range(5, 127);

    for (int p = 0; p < 6; p++) begin
      do_reset(mlist[p], (p < 4) ? p : $urandom_range(0, 3));
      for (int s = 0; s < 300; s++) begin
        step($urandom_range(0, 7), bit'($urandom_range(0, 1)),
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
             bit'($urandom_range(0, 1)));
      end
    end

    // directed R8: synthesized events alone in bypass leave fout unchanged
    do_reset(2, 1);
    for (int s = 0; s < 6; s++) step(6, 1'b0, 1'b1, 1'b0, 1'b0);
    check(fout, 1'b0, "R8 synth ignored");
    for (int s = 0; s < 2; s++) step(6, 1'b1, 1'b0, 1'b0, 1'b0);
    check(fout, 1'b1, "R8 sclk divides");

    // directed R9: output holds until the edge after a select change
    step(1, 1'b0, 1'b0, 1'b0, 1'b0);
    t_sel = 3'b101;
    #1;
    check(test_out, 1'b1, "R9 before edge");
    @(negedge clk);
    check(test_out, 1'b0, "R9 after edge");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule